// File: doc/BRIEF.md
# Pipelined Single-Precision Square Root

This block takes the square root of IEEE-754 single-precision numbers. It is fully pipelined. It accepts one operand on any clock where the input valid is high, and it returns the matching result exactly 17 clocks later. Results leave in the same order as the operands arrived. There is no back-pressure. A valid bit travels with each operand through every stage, so gaps in the input stream show up unchanged at the output.

The datapath has three parts.

- **Front stages.** An input register is followed by two left-justify stages. These classify the operand and normalise subnormal mantissas with a leading-zero count. When the unbiased exponent is odd, they double the mantissa and lower the exponent by one, so that the exponent halves exactly.
- **Root core.** Thirteen stages form a fixed-point digit-recurrence integer root. It uses only compare and subtract on a partial remainder, and each stage retires two root bits.
- **Output register.** This stage rounds to nearest-even, using a guard bit plus a sticky bit built from the last root bit and the final remainder. It also substitutes the results for zeros, infinities, NaNs and negative operands.

Top module: `fp_sqrt_pipe`

## Requirements
- R1: A result appears on the output exactly 17 clocks after its operand is accepted, with out_valid high for that one clock. Operands on consecutive clocks, and operands separated by idle clocks, come out in input order with the same spacing.
- R2: For any positive normal operand, out_data is the correctly rounded (round-to-nearest-even) single-precision square root.
- R3: Positive subnormal operands (exponent field 0, fraction nonzero) give the correctly rounded root. That root is always a normal number, with a nonzero exponent field.
- R4: Odd and even unbiased exponents both give exact results where the root is representable: 4.0 gives 2.0, 0.25 gives 0.5, and 2.0 gives 0x3FB504F3.
- R5: +0 (0x00000000) gives +0 and -0 (0x80000000) gives -0, with out_invalid low. No other output has bit 31 set.
- R6: +infinity (0x7F800000) gives +infinity with out_invalid low.
- R7: Any NaN operand (exponent field all ones, fraction nonzero, either sign) gives the quiet NaN 0x7FC00000 with out_invalid low.
- R8: Any negative nonzero non-NaN operand, including -infinity and negative subnormals, gives 0x7FC00000 with out_invalid high.
- R9: out_invalid is high only together with out_valid. Reset (rst_n low, asynchronous) clears out_valid and out_invalid, and both stay low while no operand is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operand present this clock |
| in_data | input | 32 | Operand, IEEE-754 single-precision bits |
| out_valid | output | 1 | Result present this clock |
| out_data | output | 32 | Result, IEEE-754 single-precision bits |
| out_invalid | output | 1 | Invalid-operation flag for a negative nonzero operand |

## Verification
The hardest situations to reach from the ports are the deep subnormals. Their mantissa must move many places during left-justify, and the exponent correction then lands on the odd-exponent branch. The stimulus drives fraction patterns with a single low bit, a single high bit, all ones, and values in between, so that every leading-zero count class and both exponent parities reach the root core. Rounding is exercised by a long back-to-back stream of pseudo-random normal operands. Each of these results is compared with a correctly rounded reference that the bench builds from a host real-number root.

// File: rtl/fpsq_pkg.sv
package fpsq_pkg;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int WORD_W    = 1 + EXP_W + FRAC_W;
  localparam int MANT_W    = FRAC_W + 1;
  localparam int LZ_W      = $clog2(MANT_W + 1);
  localparam int SEXP_W    = EXP_W + 2;
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN      = 1 - BIAS;
  localparam int ROOT_W    = MANT_W + 2;
  localparam int RAD_W     = 2 * ROOT_W;
  localparam int REM_W     = ROOT_W + 4;
  localparam int DIGITS    = 2;
  localparam int ROOT_STAGES = ROOT_W / DIGITS;
  localparam int FRONT_STAGES = 3;
  localparam int LATENCY   = FRONT_STAGES + ROOT_STAGES + 1;
  localparam logic [WORD_W-1:0] QNAN_WORD = 32'h7FC0_0000;
  localparam logic [WORD_W-1:0] PINF_WORD = 32'h7F80_0000;

  typedef enum logic [2:0] {
    K_FINITE  = 3'd0,
    K_ZERO    = 3'd1,
    K_INF     = 3'd2,
    K_NAN     = 3'd3,
    K_INVALID = 3'd4
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  sign;
  } tag_t;

  typedef struct packed {
    logic [REM_W-1:0]  rem;
    logic [ROOT_W-1:0] q;
  } root_pair_t;

  // Number of zeros above the leading one of a mantissa field.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [MANT_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = MANT_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n   = n + 1'b1;
      end
    end
    return n;
  endfunction

  // One radix-2 root step: bring in two radicand bits, try subtracting 4q+1.
  function automatic root_pair_t root_bit(input root_pair_t cur, input logic [1:0] dig);
    root_pair_t       nxt;
    logic [REM_W-1:0] sh;
    logic [REM_W-1:0] trial;
    sh    = {cur.rem[REM_W-3:0], dig};
    trial = {{(REM_W-ROOT_W-2){1'b0}}, cur.q, 2'b01};
    if (sh >= trial) begin
      nxt.rem = sh - trial;
      nxt.q   = {cur.q[ROOT_W-2:0], 1'b1};
    end else begin
      nxt.rem = sh;
      nxt.q   = {cur.q[ROOT_W-2:0], 1'b0};
    end
    return nxt;
  endfunction

  // Round-to-nearest-even increment from the root's guard and sticky bits.
  function automatic logic round_up(input root_pair_t p);
    logic guard;
    logic sticky;
    guard  = p.q[ROOT_W-MANT_W-1];
    sticky = (|p.q[ROOT_W-MANT_W-2:0]) | (|p.rem);
    return guard & (sticky | p.q[ROOT_W-MANT_W]);
  endfunction
endpackage

// File: rtl/fpsq_normalize.sv
module fpsq_normalize
  import fpsq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [WORD_W-1:0]        in_data,
  output logic                     out_valid,
  output tag_t                     out_tag,
  output logic [MANT_W-1:0]        out_mant,
  output logic signed [SEXP_W-1:0] out_exp
);
  logic                     sgn;
  logic [EXP_W-1:0]         bexp;
  logic [FRAC_W-1:0]        frac;
  logic [MANT_W-1:0]        mant_raw;
  logic [LZ_W-1:0]          lz;
  tag_t                     tag_c;
  logic [MANT_W-1:0]        mant_c;
  logic signed [SEXP_W-1:0] exp_c;

  always_comb begin
    sgn  = in_data[WORD_W-1];
    bexp = in_data[WORD_W-2 -: EXP_W];
    frac = in_data[FRAC_W-1:0];
    tag_c.sign = sgn;
    if (&bexp) begin
      if (|frac)    tag_c.kind = K_NAN;
      else if (sgn) tag_c.kind = K_INVALID;
      else          tag_c.kind = K_INF;
    end else if (bexp == '0 && frac == '0) begin
      tag_c.kind = K_ZERO;
    end else if (sgn) begin
      tag_c.kind = K_INVALID;
    end else begin
      tag_c.kind = K_FINITE;
    end
    mant_raw = {(bexp != '0), frac};
    lz       = (bexp == '0) ? lead_zeros(mant_raw) : '0;
    mant_c   = mant_raw << lz;
    if (bexp == '0)
      exp_c = SEXP_W'(EMIN) - $signed({{(SEXP_W-LZ_W){1'b0}}, lz});
    else
      exp_c = $signed({{(SEXP_W-EXP_W){1'b0}}, bexp}) - SEXP_W'(BIAS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    out_tag  <= tag_c;
    out_mant <= mant_c;
    out_exp  <= exp_c;
  end
endmodule

// File: rtl/fpsq_align.sv
module fpsq_align
  import fpsq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  tag_t                     in_tag,
  input  logic [MANT_W-1:0]        in_mant,
  input  logic signed [SEXP_W-1:0] in_exp,
  output logic                     out_valid,
  output tag_t                     out_tag,
  output logic [EXP_W-1:0]         out_exp,
  output logic [RAD_W-1:0]         out_rad
);
  logic                     odd;
  logic signed [SEXP_W-1:0] e_even;
  logic signed [SEXP_W-1:0] e_res;
  logic [RAD_W-1:0]         rad_c;

  always_comb begin
    odd    = in_exp[0];
    e_even = in_exp - $signed({{(SEXP_W-1){1'b0}}, odd});
    e_res  = (e_even >>> 1) + SEXP_W'(BIAS);
    if (odd) rad_c = {in_mant, {(RAD_W-MANT_W){1'b0}}};
    else     rad_c = {1'b0, in_mant, {(RAD_W-MANT_W-1){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    out_tag <= in_tag;
    out_exp <= e_res[EXP_W-1:0];
    out_rad <= rad_c;
  end
endmodule

// File: rtl/fpsq_root_stage.sv
module fpsq_root_stage
  import fpsq_pkg::*;
#(
  parameter int STEPS = DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  tag_t             in_tag,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [RAD_W-1:0] in_rad,
  input  root_pair_t       in_rp,
  output logic             out_valid,
  output tag_t             out_tag,
  output logic [EXP_W-1:0] out_exp,
  output logic [RAD_W-1:0] out_rad,
  output root_pair_t       out_rp
);
  root_pair_t       p;
  logic [RAD_W-1:0] r;

  always_comb begin
    p = in_rp;
    r = in_rad;
    for (int k = 0; k < STEPS; k++) begin
      p = root_bit(p, r[RAD_W-1 -: 2]);
      r = {r[RAD_W-3:0], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    out_tag <= in_tag;
    out_exp <= in_exp;
    out_rad <= r;
    out_rp  <= p;
  end
endmodule

// File: rtl/fpsq_round.sv
module fpsq_round
  import fpsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  tag_t              in_tag,
  input  logic [EXP_W-1:0]  in_exp,
  input  root_pair_t        in_rp,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_invalid
);
  logic [WORD_W-2:0] mag;
  logic [WORD_W-1:0] res_c;

  always_comb begin
    mag = {in_exp, in_rp.q[ROOT_W-2 -: FRAC_W]} + {{(WORD_W-2){1'b0}}, round_up(in_rp)};
    unique case (in_tag.kind)
      K_ZERO:   res_c = {in_tag.sign, {(WORD_W-1){1'b0}}};
      K_INF:    res_c = PINF_WORD;
      K_FINITE: res_c = {1'b0, mag};
      default:  res_c = QNAN_WORD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid && (in_tag.kind == K_INVALID);
    end
  end

  always_ff @(posedge clk) out_data <= res_c;
endmodule

// File: rtl/fp_sqrt_pipe.sv
module fp_sqrt_pipe
  import fpsq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        out_invalid
);
  logic              s0_valid;
  logic [WORD_W-1:0] s0_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s0_valid <= 1'b0;
    else        s0_valid <= in_valid;
  end

  always_ff @(posedge clk) s0_data <= in_data;

  logic                     norm_valid;
  tag_t                     norm_tag;
  logic [MANT_W-1:0]        norm_mant;
  logic signed [SEXP_W-1:0] norm_exp;

  fpsq_normalize u_norm (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s0_valid), .in_data(s0_data),
    .out_valid(norm_valid), .out_tag(norm_tag),
    .out_mant(norm_mant), .out_exp(norm_exp)
  );

  logic              al_valid;
  tag_t              al_tag;
  logic [EXP_W-1:0]  al_exp;
  logic [RAD_W-1:0]  al_rad;

  fpsq_align u_align (
    .clk(clk), .rst_n(rst_n),
    .in_valid(norm_valid), .in_tag(norm_tag),
    .in_mant(norm_mant), .in_exp(norm_exp),
    .out_valid(al_valid), .out_tag(al_tag),
    .out_exp(al_exp), .out_rad(al_rad)
  );

  logic             v_s   [0:ROOT_STAGES];
  tag_t             tag_s [0:ROOT_STAGES];
  logic [EXP_W-1:0] exp_s [0:ROOT_STAGES];
  logic [RAD_W-1:0] rad_s [0:ROOT_STAGES];
  root_pair_t       rp_s  [0:ROOT_STAGES];

  assign v_s[0]   = al_valid;
  assign tag_s[0] = al_tag;
  assign exp_s[0] = al_exp;
  assign rad_s[0] = al_rad;
  assign rp_s[0]  = '0;

  for (genvar g = 0; g < ROOT_STAGES; g++) begin : g_root
    fpsq_root_stage #(.STEPS(DIGITS)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(v_s[g]), .in_tag(tag_s[g]), .in_exp(exp_s[g]),
      .in_rad(rad_s[g]), .in_rp(rp_s[g]),
      .out_valid(v_s[g+1]), .out_tag(tag_s[g+1]), .out_exp(exp_s[g+1]),
      .out_rad(rad_s[g+1]), .out_rp(rp_s[g+1])
    );
  end

  // Named observation points for the checker.
  kind_e      norm_kind_w;
  logic       root_last_valid_w;
  root_pair_t root_last_w;
  assign norm_kind_w       = norm_tag.kind;
  assign root_last_valid_w = v_s[ROOT_STAGES];
  assign root_last_w       = rp_s[ROOT_STAGES];

  fpsq_round u_round (
    .clk(clk), .rst_n(rst_n),
    .in_valid(v_s[ROOT_STAGES]), .in_tag(tag_s[ROOT_STAGES]),
    .in_exp(exp_s[ROOT_STAGES]), .in_rp(rp_s[ROOT_STAGES]),
    .out_valid(out_valid), .out_data(out_data), .out_invalid(out_invalid)
  );
endmodule

// File: rtl/fp_sqrt_pipe_chk.sv
module fp_sqrt_pipe_chk
  import fpsq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic        out_invalid,
  input logic [31:0] out_data,
  input logic        norm_valid,
  input kind_e       norm_kind,
  input logic [MANT_W-1:0] norm_mant,
  input logic        root_valid,
  input root_pair_t  root_rp
);
  logic [LATENCY-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[LATENCY-2:0], in_valid};
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[LATENCY-1]); // R1
  AST_ROOT_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    root_valid |-> ({1'b0, root_rp.rem} <= {{(REM_W-ROOT_W){1'b0}}, root_rp.q, 1'b0})); // R2
  AST_LEFT_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_valid && norm_kind == K_FINITE) |-> norm_mant[MANT_W-1]); // R3
  AST_RESULT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid && out_data[30:0] != '0) |-> (out_data[30:23] != '0)); // R3
  AST_ONLY_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[31]) |-> (out_data[30:0] == '0)); // R5
  AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_data == QNAN_WORD)); // R8
  AST_INVALID_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> out_valid); // R9
endmodule

bind fp_sqrt_pipe fp_sqrt_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .out_invalid(out_invalid), .out_data(out_data),
  .norm_valid(norm_valid), .norm_kind(norm_kind_w), .norm_mant(norm_mant),
  .root_valid(root_last_valid_w), .root_rp(root_last_w)
);

// File: tb/fp_sqrt_pipe_tb.sv
`timescale 1ns/1ps
module fp_sqrt_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [32:0] exp_q [$];
  logic [31:0] in_q  [$];
  int          req_q [$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_sqrt_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_invalid(out_invalid)
  );

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else        repeat (-k) r = r / 2.0;
    return r;
  endfunction

  // Reference: {invalid, result} from a host double root, rounded to single.
  function automatic logic [32:0] ref_sqrt(input logic [31:0] x);
    logic       s;
    int         e;
    int         f;
    int         k;
    int         ip;
    int         m;
    real        v;
    real        r;
    real        sc;
    real        fr;
    logic [7:0] eb;
    s = x[31];
    e = int'(x[30:23]);
    f = int'(x[22:0]);
    if (e == 255) begin
      if (f != 0) return {1'b0, 32'h7FC0_0000};
      if (s)      return {1'b1, 32'h7FC0_0000};
      return {1'b0, 32'h7F80_0000};
    end
    if (e == 0 && f == 0) return {1'b0, s, 31'b0};
    if (s) return {1'b1, 32'h7FC0_0000};
    if (e == 0) v = real'(f) * pow2(-149);
    else        v = real'(f + 8388608) * pow2(e - 150);
    r = $sqrt(v);
    k = 0;
    while (r >= 2.0) begin r = r / 2.0; k++; end
    while (r < 1.0)  begin r = r * 2.0; k--; end
    sc = r * 8388608.0;
    ip = $rtoi(sc);
    fr = sc - real'(ip);
    m  = ip;
    if (fr > 0.5 || (fr == 0.5 && (ip % 2) == 1)) m = ip + 1;
    if (m == 16777216) begin m = 8388608; k++; end
    eb = 8'(k + 127);
    return {1'b0, 1'b0, eb, 23'(m)};
  endfunction

  task automatic fail_line(input int req, input string what, input logic [32:0] got, input logic [32:0] want);
    errors++;
    $display("FAIL R%0d %s: got inv=%b data=%h expected inv=%b data=%h",
             req, what, got[32], got[31:0], want[32], want[31:0]);
  endtask

  // Output monitor: each result compared with the reference, in order.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fail_line(1, "unexpected result", {out_invalid, out_data}, 33'h0);
      end else begin
        logic [32:0] w;
        logic [31:0] xi;
        int          rq;
        w  = exp_q.pop_front();
        xi = in_q.pop_front();
        rq = req_q.pop_front();
        if ({out_invalid, out_data} !== w)
          fail_line(rq, $sformatf("operand %h", xi), {out_invalid, out_data}, w);
      end
    end
  end

  task automatic send(input logic [31:0] x, input int req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    exp_q.push_back(ref_sqrt(x));
    in_q.push_back(x);
    req_q.push_back(req);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
    end
  endtask

  task automatic drain(input int req);
    idle(1);
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    checks++;
    if (exp_q.size() != 0)
      fail_line(req, "results missing", 33'(exp_q.size()), 33'h0);
  endtask

  task automatic t_reset; // R9
    checks++;
    if (out_valid !== 1'b0 || out_invalid !== 1'b0)
      fail_line(9, "reset state", {out_invalid, 31'b0, out_valid}, 33'h0);
  endtask

  task automatic t_latency; // R1
    int t0;
    int lat;
    send(32'h4080_0000, 1);
    t0 = cyc;
    idle(1);
    for (int i = 0; i < 40 && !out_valid; i++) @(negedge clk);
    lat = cyc - t0;
    checks++;
    if (lat != 17) fail_line(1, "latency", 33'(lat), 33'd17);
    drain(1);
  endtask

  task automatic t_specials; // R5 R6 R7
    send(32'h0000_0000, 5);
    send(32'h8000_0000, 5);
    send(32'h7F80_0000, 6);
    send(32'h7FC0_0000, 7);
    send(32'h7F80_0001, 7);
    send(32'hFFC0_1234, 7);
    drain(7);
  endtask

  task automatic t_negative; // R8
    send(32'hBF80_0000, 8);
    send(32'hFF80_0000, 8);
    send(32'h8000_0001, 8);
    send(32'hFF7F_FFFF, 8);
    send(32'h4000_0000, 8);
    drain(8);
  endtask

  task automatic t_exponents; // R4
    send(32'h4080_0000, 4);
    send(32'h3E80_0000, 4);
    send(32'h4000_0000, 4);
    send(32'h3F80_0000, 4);
    send(32'h3F00_0000, 4);
    send(32'h4040_0000, 4);
    send(32'h7F7F_FFFF, 4);
    send(32'h0080_0000, 4);
    drain(4);
  endtask

  task automatic t_subnormal; // R3
    send(32'h0000_0001, 3);
    send(32'h0000_0002, 3);
    send(32'h0000_0003, 3);
    send(32'h007F_FFFF, 3);
    send(32'h0040_0000, 3);
    send(32'h0020_0000, 3);
    send(32'h0001_2345, 3);
    send(32'h0000_0F0F, 3);
    drain(3);
  endtask

  task automatic t_random; // R2, back-to-back operands for R1
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  e;
      logic [22:0] f;
      e = 8'(1 + ($urandom % 254));
      f = 23'($urandom);
      send({1'b0, e, f}, 2);
    end
    drain(2);
  endtask

  task automatic t_bubbles; // R1
    for (int i = 0; i < 20; i++) begin
      send({1'b0, 8'(100 + i), 23'(i * 40503)}, 1);
      idle(i % 3);
    end
    drain(1);
  endtask

  task automatic t_quiet; // R9
    int bad = 0;
    idle(2);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (out_valid !== 1'b0 || out_invalid !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) fail_line(9, "activity while idle", 33'(bad), 33'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_latency();
    t_specials();
    t_negative();
    t_exponents();
    t_subnormal();
    t_random();
    t_bubbles();
    t_quiet();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule